// File: doc/BRIEF.md
# Delay-Tolerant Register Bank with Single-Cycle Replay

This block is a bank of flip-flops that catches data arriving late at its inputs and repairs the stored value without a second storage element per bit. Each checked bit compares the value at its flop input with the value the flop holds. Any difference seen just after the main clock edge means the data changed too late. A bank-wide flag samples the OR of all per-bit differences on a second clock, `mem_clk`, which runs a short fixed offset behind `clk`. While the flag is set, each checked bit's input multiplexer feeds back the value it captured at the `mem_clk` edge. The next `clk` edge then reloads the flop with the late but settled value. Recovery therefore costs exactly one extra evaluation cycle. The upstream stage must hold its data steady through that cycle, because the bank ignores `d` while it replays.

Some bits sit at the ends of short paths, where data can never be late. A parameter mask marks these bits as frozen. A frozen bit has no comparator. During the replay cycle it recirculates its own output, so it keeps its value. Every bit also sits on a serial scan chain. When `scan_en` is high, the chain shifts toward the most significant bit, and error detection is suppressed for the duration of the shift.

Top module: `td_scan_reg`

## Requirements
- R1: With `scan_en` low and `error_r` low at a `clk` rising edge, every bit of `q` takes the value `d` had at that edge.
- R2: If a checked bit's `d` changes after a `clk` edge and before the following `mem_clk` edge, so that it no longer equals `q`, then `error_r` is high from that `mem_clk` edge until the next `mem_clk` edge.
- R3: At the `clk` edge that follows a raised `error_r`, every checked bit of `q` takes the value `d` had at the `mem_clk` edge that raised the flag.
- R4: During the replay cycle (the cycle in which `error_r` is high), `d` has no effect: neither `q` at the replay edge nor `error_r` afterwards depends on it.
- R5: `error_r` is never high at two consecutive `mem_clk` edges. After one replay, the bank returns to normal capture.
- R6: A late change confined to frozen bits (bits set in `FREEZE_MASK`) raises no error, and those bits keep the value captured at the `clk` edge.
- R7: At a replay edge, every frozen bit of `q` keeps its previous value.
- R8: With `scan_en` high, each `clk` edge shifts the chain: `q[0]` takes `scan_in`, `q[i]` takes the old `q[i-1]`, and `scan_out` always equals `q[WIDTH-1]`.
- R9: While `scan_en` is high at a `mem_clk` edge, `error_r` is low after that edge, whatever the data does.
- R10: While `rst_n` is low, `q` is all zeros and `error_r` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main capture clock |
| mem_clk | input | 1 | Delayed copy of `clk` that samples the error flag and the hold values |
| rst_n | input | 1 | Asynchronous active-low reset |
| d | input | WIDTH | Data from the upstream logic |
| scan_en | input | 1 | Selects serial shift through the chain |
| scan_in | input | 1 | Serial input to bit 0 |
| scan_out | output | 1 | Serial output from bit WIDTH-1 |
| q | output | WIDTH | Registered data |
| error_r | output | 1 | Bank error flag; high during a replay cycle |

## Verification
The bench changes `d` in the narrow gap between the two clock edges and checks the replayed value. A design that reloaded the early value, or captured the hold value at the wrong edge, would leave `q` one value behind. It also changes `d` again during the replay cycle. A design that let the data path through would load that newer value, or raise a second, back-to-back error. Late changes confined to the frozen bit must stay silent and uncorrected, and a bank that compared frozen bits would raise a false flag. A scan shift with data churning underneath must neither set the flag nor leave a stale hold value for the first functional capture after the shift.

// File: rtl/td_pkg.sv
`timescale 1ns/1ps
package td_pkg;

   // Source picked by each bit's input multiplexer
   typedef enum logic [1:0] {
      SRC_DATA = 2'd0,
      SRC_HOLD = 2'd1,
      SRC_SCAN = 2'd2
   } td_src_e;

   // Scan has priority over replay; replay over live data
   function automatic td_src_e td_select(input logic scan_en, input logic replay);
      if (scan_en)
         return SRC_SCAN;
      else if (replay)
         return SRC_HOLD;
      return SRC_DATA;
   endfunction

endpackage

// File: rtl/td_bank.sv
`timescale 1ns/1ps
module td_bank #(
   parameter int                 WIDTH       = 8,
   parameter logic [WIDTH-1:0]   FREEZE_MASK = '0
) (
   input  logic             clk,
   input  logic             mem_clk,
   input  logic             rst_n,
   input  logic             replay,
   input  logic             scan_en,
   input  logic             scan_in,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] mismatch
);
   import td_pkg::*;

   td_src_e          src;
   logic [WIDTH-1:0] m_in;
   logic [WIDTH-1:0] chain_in;

   assign src      = td_select(scan_en, replay);
   assign chain_in = {q[WIDTH-2:0], scan_in};

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (FREEZE_MASK[i]) begin : g_freeze
         // Short-path bit: never late, so it recirculates its own output
         always_comb begin
            case (src)
               SRC_SCAN: m_in[i] = chain_in[i];
               SRC_HOLD: m_in[i] = q[i];
               default:  m_in[i] = d[i];
            endcase
         end
         assign mismatch[i] = 1'b0;
      end else begin : g_check
         logic hold;
         // Hold element closes at the delayed edge while replay is off
         always_ff @(posedge mem_clk or negedge rst_n) begin
            if (!rst_n)
               hold <= 1'b0;
            else if (!replay)
               hold <= d[i];
         end
         always_comb begin
            case (src)
               SRC_SCAN: m_in[i] = chain_in[i];
               SRC_HOLD: m_in[i] = hold;
               default:  m_in[i] = d[i];
            endcase
         end
         assign mismatch[i] = m_in[i] ^ q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= 1'b0;
         else
            q[i] <= m_in[i];
      end
   end

endmodule

// File: rtl/td_err_ctrl.sv
`timescale 1ns/1ps
module td_err_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic             mem_clk,
   input  logic             rst_n,
   input  logic             scan_en,
   input  logic [WIDTH-1:0] mismatch,
   output logic             replay
);
   logic any_mismatch;

   assign any_mismatch = |mismatch;

   // One replay per detection; scan shifts never start a replay
   always_ff @(posedge mem_clk or negedge rst_n) begin
      if (!rst_n)
         replay <= 1'b0;
      else
         replay <= any_mismatch & ~scan_en;
   end

endmodule

// File: rtl/td_scan_reg.sv
`timescale 1ns/1ps
module td_scan_reg #(
   parameter int               WIDTH       = 8,
   parameter logic [WIDTH-1:0] FREEZE_MASK = 8'h80
) (
   input  logic             clk,
   input  logic             mem_clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   input  logic             scan_en,
   input  logic             scan_in,
   output logic             scan_out,
   output logic [WIDTH-1:0] q,
   output logic             error_r
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("td_scan_reg: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] mismatch;
   logic             replay;

   td_bank #(
      .WIDTH       (WIDTH),
      .FREEZE_MASK (FREEZE_MASK)
   ) u_bank (
      .clk      (clk),
      .mem_clk  (mem_clk),
      .rst_n    (rst_n),
      .replay   (replay),
      .scan_en  (scan_en),
      .scan_in  (scan_in),
      .d        (d),
      .q        (q),
      .mismatch (mismatch)
   );

   td_err_ctrl #(
      .WIDTH (WIDTH)
   ) u_ctrl (
      .mem_clk  (mem_clk),
      .rst_n    (rst_n),
      .scan_en  (scan_en),
      .mismatch (mismatch),
      .replay   (replay)
   );

   assign error_r  = replay;
   assign scan_out = q[LAST];

endmodule

// File: rtl/td_scan_reg_chk.sv
`timescale 1ns/1ps
module td_scan_reg_chk #(
   parameter int               WIDTH       = 8,
   parameter logic [WIDTH-1:0] FREEZE_MASK = 8'h80
) (
   input logic             clk,
   input logic             mem_clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] d,
   input logic             scan_en,
   input logic             scan_in,
   input logic [WIDTH-1:0] q,
   input logic             error_r
);

   AST_NORMAL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!error_r && !scan_en) |=> (q == $past(d)));   // R1

   AST_FROZEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (error_r && !scan_en) |=> ((q & FREEZE_MASK) == ($past(q) & FREEZE_MASK)));   // R7

   AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> (q == {$past(q[WIDTH-2:0]), $past(scan_in)}));   // R8

   AST_SINGLE_REPLAY: assert property (@(posedge mem_clk) disable iff (!rst_n)
      error_r |=> !error_r);   // R5

   AST_SCAN_QUIET: assert property (@(posedge mem_clk) disable iff (!rst_n)
      scan_en |=> !error_r);   // R9

endmodule

bind td_scan_reg td_scan_reg_chk #(
   .WIDTH       (WIDTH),
   .FREEZE_MASK (FREEZE_MASK)
) u_chk (
   .clk     (clk),
   .mem_clk (mem_clk),
   .rst_n   (rst_n),
   .d       (d),
   .scan_en (scan_en),
   .scan_in (scan_in),
   .q       (q),
   .error_r (error_r)
);

// File: tb/sim_td_scan_reg.sv
`timescale 1ns/1ps
module sim_td_scan_reg;
   localparam int               W  = 8;
   localparam logic [W-1:0]     FM = 8'h80;
   localparam int               NV = 11;
   typedef logic [2*W:0] vec_t;   // {early, late_en, late}

   // Walk: normal, late fix, replay with ignored d, frozen-only late,
   // multi-bit late, late during replay, back-to-back detections
   localparam vec_t VEC [NV] = '{
      {8'h12, 1'b0, 8'h00},
      {8'h34, 1'b1, 8'h35},
      {8'hAA, 1'b0, 8'h00},
      {8'hAA, 1'b0, 8'h00},
      {8'h0F, 1'b1, 8'h8F},
      {8'h55, 1'b1, 8'hC3},
      {8'h00, 1'b1, 8'hFF},
      {8'h66, 1'b0, 8'h00},
      {8'h66, 1'b1, 8'h67},
      {8'h66, 1'b0, 8'h00},
      {8'h81, 1'b1, 8'h01}
   };

   logic         clk = 1'b0, mem_clk = 1'b0, rst_n = 1'b0;
   logic         scan_en = 1'b0, scan_in = 1'b0;
   logic [W-1:0] d = '1;
   logic [W-1:0] q;
   logic         scan_out, error_r;

   int   checks = 0, errors = 0;
   logic done = 1'b0;

   logic [W-1:0] e_q = '0, e_hold = '0;
   logic         e_mem = 1'b0;

   td_scan_reg #(.WIDTH(W), .FREEZE_MASK(FM)) u0 (
      .clk(clk), .mem_clk(mem_clk), .rst_n(rst_n), .d(d),
      .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
      .q(q), .error_r(error_r)
   );

   initial forever #2.5 clk = ~clk;
   always @(clk) begin
      #1;
      mem_clk = clk;
   end

   task automatic chk_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic chk_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // One clk period; outputs settle by posedge+2
   task automatic cycle(input logic [W-1:0] early, input logic late_en,
                        input logic [W-1:0] late, input logic sen, input logic sin);
      logic [W-1:0] dnow, mv;
      @(negedge clk);
      d = early; scan_en = sen; scan_in = sin;
      @(posedge clk);
      if (sen)        e_q = {e_q[W-2:0], sin};
      else if (e_mem) e_q = (e_hold & ~FM) | (e_q & FM);
      else            e_q = early;
      #0.5;
      if (late_en) d = late;
      if (sen) e_mem = 1'b0;
      else begin
         dnow = late_en ? late : early;
         mv   = e_mem ? ((e_hold & ~FM) | (e_q & FM)) : dnow;
         if (!e_mem) e_hold = dnow;
         e_mem = (((mv ^ e_q) & ~FM) != '0);
      end
      #1.5;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog act=running exp=finished");
         summary();
      end
   end

   initial begin
      logic [W-1:0] pat;
      // R10: reset holds everything low even with d all ones
      repeat (3) @(posedge clk);
      #2;
      chk_vec("R10 q in reset", q, '0);
      chk_bit("R10 error_r in reset", error_r, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R3 R4 R5 R6 R7: vector walk
      for (int i = 0; i < NV; i++) begin
         cycle(VEC[i][2*W:W+1], VEC[i][W], VEC[i][W-1:0], 1'b0, 1'b0);
         chk_vec($sformatf("R1 R3 R4 R6 R7 q vec%0d", i), q, e_q);
         chk_bit($sformatf("R2 R4 R5 R6 error_r vec%0d", i), error_r, e_mem);
      end

      // R8 R9: scan shift with data churning late underneath
      pat = 8'b1011_0010;
      for (int k = 0; k < W; k++) begin
         cycle(8'h5A, 1'b1, 8'hA5, 1'b1, pat[W-1-k]);
         chk_bit($sformatf("R8 scan_out shift%0d", k), scan_out, e_q[W-1]);
         chk_bit($sformatf("R9 error_r shift%0d", k), error_r, 1'b0);
      end
      chk_vec("R8 q after scan load", q, pat);

      // R1 then R3: first captures after scan use fresh data, not stale hold
      cycle(8'h3C, 1'b0, 8'h00, 1'b0, 1'b0);
      chk_vec("R1 q after scan", q, 8'h3C);
      chk_bit("R2 quiet after scan", error_r, 1'b0);
      cycle(8'h3C, 1'b1, 8'h3D, 1'b0, 1'b0);
      chk_bit("R2 late after scan", error_r, 1'b1);
      cycle(8'h11, 1'b0, 8'h00, 1'b0, 1'b0);
      chk_vec("R3 replay after scan", q, 8'h3D);
      chk_bit("R5 flag clears", error_r, 1'b0);

      // R10: reset during a pending replay
      cycle(8'h20, 1'b1, 8'h21, 1'b0, 1'b0);
      chk_bit("R2 late before reset", error_r, 1'b1);
      rst_n = 1'b0;
      #0.5;
      chk_vec("R10 q after mid-replay reset", q, '0);
      chk_bit("R10 error_r after mid-replay reset", error_r, 1'b0);

      done = 1'b1;
      summary();
   end

endmodule